// File: doc/BRIEF.md
# Nibble-Mode Video Serializer

This block takes 8-bit video samples and sends each one as two 4-bit nibbles, most significant nibble first, on a narrow output lane. That lane stands for the upper four bits of a video data port. The lower bits and the second data port stay unused. The block runs on the fast nibble clock and accepts one byte every second cycle while the line reference input is high. It pulses `take_o` in the cycle it captures a byte. It also drives `req_o` with the component it expects in that slot, so the upstream formatter can present the right sample.

The source format is selected with `mode_i`:

- **Colour mode.** Components arrive in a fixed U, Y, V, Y order. Each pixel costs two bytes, so the nibble clock runs at four times the pixel rate. Seen from the source, the byte clock is the nibble clock divided by two.
- **Monochrome and one-line raw modes.** Each pixel is one byte, so the nibble clock runs at twice the pixel rate.

The output strobe and a delayed copy of the line reference line up with the nibbles. A downstream receiver can frame the nibbles without counting cycles of its own.

Top module: `nibser_top`

## Requirements
- R1: While reset (`rst_n` low) is applied, `nib_o` is 0 and `nib_stb_o` and `line_ref_o` are low. `take_o` is low while `line_ref_i` is low.
- R2: `line_ref_o` equals `line_ref_i` delayed by one clock, and `nib_stb_o` is high exactly when `line_ref_o` is high.
- R3: In a cycle after one where `line_ref_i` was low, `nib_o` is 0 and `nib_stb_o` is low. No byte is taken while `line_ref_i` is low.
- R4: A byte taken in cycle t shows its bits 7..4 on `nib_o` in cycle t+1 and its bits 3..0 in cycle t+2.
- R5: The rising edge of `line_ref_i` restarts the phase, and the byte is taken in that same cycle. After that, `take_o` is high on every second cycle while `line_ref_i` stays high.
- R6: With `mode_i` = 0 (colour), `req_o` steps through the codes 1 (U), 0 (Y), 2 (V), 0 (Y), one code per taken byte, starting at U at line start. A pixel therefore takes 4 clocks.
- R7: With `mode_i` = 1 (monochrome), `req_o` is always 0 (Y). With `mode_i` = 2 or 3 (one-line raw), `req_o` is always 3. A pixel takes 2 clocks in both.
- R8: In colour mode, a byte taken with `tag_i` = 1 (U) restarts the component order from U. The next byte requested is Y (0).
- R9: In monochrome and raw modes, `tag_i` has no effect on `req_o`, `take_o` or `nib_o`.
- R10: If `line_ref_i` falls right after a byte is taken, that byte's low nibble is dropped (`nib_o` = 0, strobe low). The next line again starts with a take, and in colour mode with U.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Source format: 0 colour, 1 monochrome, 2/3 one-line raw |
| line_ref_i | input | 1 | Line reference, high during active samples |
| data_i | input | DATA_W | Sample byte presented by the source |
| tag_i | input | 2 | Component tag of `data_i`: 0 Y, 1 U, 2 V, 3 raw |
| take_o | output | 1 | High in the cycle `data_i` is captured |
| req_o | output | 2 | Component code expected in the current slot |
| nib_o | output | DATA_W/2 | Serialized nibble |
| nib_stb_o | output | 1 | Nibble valid strobe |
| line_ref_o | output | 1 | Line reference aligned with the nibbles |

## Verification
The hardest situations to reach are a U tag arriving in the middle of a colour pixel pair, and a line that ends right after a byte is captured. A cooperative source never produces either one. The stimulus forces both. It injects a U-tagged byte in the V slot of a colour line, and it ends a raw line after an odd number of clocks before starting a colour line. A behavioural model then confirms two things: the component order restarts from U, and the stranded low nibble never appears.

// File: rtl/nibser_pkg.sv
package nibser_pkg;

    typedef enum logic [1:0] {
        MODE_COLOUR = 2'd0,
        MODE_MONO   = 2'd1,
        MODE_RAW    = 2'd2,
        MODE_RAW2   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        TAG_Y   = 2'd0,
        TAG_U   = 2'd1,
        TAG_V   = 2'd2,
        TAG_RAW = 2'd3
    } tag_e;

    // Component slots in one colour pixel pair.
    localparam int COLOUR_SLOTS = 4;
    localparam int SLOT_W       = $clog2(COLOUR_SLOTS);
    localparam int PH_W         = SLOT_W + 1;

    function automatic tag_e colour_slot_tag(input logic [SLOT_W-1:0] slot);
        case (slot)
            2'd0:    return TAG_U;
            2'd2:    return TAG_V;
            default: return TAG_Y;
        endcase
    endfunction

endpackage

// File: rtl/nibser_phase.sv
module nibser_phase
    import nibser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       line_ref_i,
    input  logic [1:0] tag_i,
    output logic       take_o,
    output logic [1:0] req_o
);

    typedef struct packed {
        logic            prev;
        logic [PH_W-1:0] ph;
    } phase_t;

    phase_t q, d;

    logic            rise;
    logic            colour;
    logic [PH_W-1:0] ph_eff;
    logic [PH_W-1:0] ph_adv;
    tag_e            req;

    always_comb begin
        d      = q;
        rise   = line_ref_i & ~q.prev;
        ph_eff = rise ? '0 : q.ph;
        colour = (mode_e'(mode_i) == MODE_COLOUR);

        if (colour) begin
            req = colour_slot_tag(ph_eff[PH_W-1:1]);
        end else if (mode_e'(mode_i) == MODE_MONO) begin
            req = TAG_Y;
        end else begin
            req = TAG_RAW;
        end

        take_o = line_ref_i & ~ph_eff[0];

        // A U byte always opens a pixel pair.
        ph_adv = ph_eff;
        if (colour && take_o && (tag_e'(tag_i) == TAG_U)) begin
            ph_adv = '0;
        end

        d.prev = line_ref_i;
        if (!line_ref_i) begin
            d.ph = '0;
        end else if (colour) begin
            d.ph = ph_adv + 1'b1;
        end else begin
            d.ph = {{(PH_W-1){1'b0}}, ~ph_adv[0]};
        end
    end

    assign req_o = req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nibser_lane.sv
module nibser_lane #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_ref_i,
    input  logic                take_i,
    input  logic [DATA_W-1:0]   data_i,
    output logic [DATA_W/2-1:0] nib_o,
    output logic                stb_o,
    output logic                line_ref_o
);

    localparam int NIB_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [NIB_W-1:0]  nib;
        logic              stb;
        logic              lref;
    } lane_t;

    lane_t q, d;

    always_comb begin
        d      = q;
        d.stb  = line_ref_i;
        d.lref = line_ref_i;
        if (!line_ref_i) begin
            d.nib = '0;
        end else if (take_i) begin
            d.hold = data_i;
            d.nib  = data_i[DATA_W-1:NIB_W];
        end else begin
            d.nib = q.hold[NIB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign nib_o      = q.nib;
    assign stb_o      = q.stb;
    assign line_ref_o = q.lref;

endmodule

// File: rtl/nibser_top.sv
module nibser_top #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                line_ref_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic [1:0]          tag_i,
    output logic                take_o,
    output logic [1:0]          req_o,
    output logic [DATA_W/2-1:0] nib_o,
    output logic                nib_stb_o,
    output logic                line_ref_o
);

    logic take;

    nibser_phase phase_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .line_ref_i (line_ref_i),
        .tag_i      (tag_i),
        .take_o     (take),
        .req_o      (req_o)
    );

    nibser_lane #(.DATA_W(DATA_W)) lane_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_ref_i (line_ref_i),
        .take_i     (take),
        .data_i     (data_i),
        .nib_o      (nib_o),
        .stb_o      (nib_stb_o),
        .line_ref_o (line_ref_o)
    );

    assign take_o = take;

endmodule

// File: rtl/nibser_chk.sv
module nibser_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode_i,
    input logic                line_ref_i,
    input logic [DATA_W-1:0]   data_i,
    input logic                take_o,
    input logic [1:0]          req_o,
    input logic [DATA_W/2-1:0] nib_o,
    input logic                nib_stb_o,
    input logic                line_ref_o
);

    localparam int NIB_W = DATA_W / 2;

    logic [NIB_W-1:0] saved_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_low <= '0;
        end else if (take_o) begin
            saved_low <= data_i[NIB_W-1:0];
        end
    end

    assert_active_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_ref_i |=> (line_ref_o && nib_stb_o));

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !line_ref_i |=> (!line_ref_o && !nib_stb_o && nib_o == '0));

    assert_high_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (nib_o == $past(data_i[DATA_W-1:NIB_W])));

    assert_low_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ref_i && !take_o) |=> (nib_o == $past(saved_low)));

    assert_take_alternates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_rise_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ref_i && !$past(line_ref_i)) |-> take_o);

    assert_mono_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1) |-> (req_o == 2'd0));

endmodule

bind nibser_top nibser_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .line_ref_i (line_ref_i),
    .data_i     (data_i),
    .take_o     (take_o),
    .req_o      (req_o),
    .nib_o      (nib_o),
    .nib_stb_o  (nib_stb_o),
    .line_ref_o (line_ref_o)
);

// File: tb/nibser_top_tb.sv
module nibser_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       lref;
    logic [7:0] data;
    logic [1:0] tag;
    logic       take_o;
    logic [1:0] req_o;
    logic [3:0] nib_o;
    logic       nib_stb_o;
    logic       line_ref_o;

    always #5 clk = ~clk;

    nibser_top #(.DATA_W(8)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .line_ref_i (lref),
        .data_i     (data),
        .tag_i      (tag),
        .take_o     (take_o),
        .req_o      (req_o),
        .nib_o      (nib_o),
        .nib_stb_o  (nib_stb_o),
        .line_ref_o (line_ref_o)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R4";

    // Reference model state.
    bit m_prev = 0;
    int m_ph   = 0;
    int m_hold = 0;
    int e_nib  = 0;
    bit e_stb  = 0;
    bit e_lref = 0;

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    function automatic int colour_code(input int ph);
        int order[4] = '{1, 0, 2, 0};
        return order[(ph / 2) % 4];
    endfunction

    // tg < 0 means present the requested component.
    task automatic cyc(input bit lr, input int d, input int tg);
        bit rise;
        int ph;
        int req_exp;
        bit take_exp;
        int t;
        @(negedge clk);
        chk(cur_req, int'(nib_o), e_nib);
        chk("R2", int'(nib_stb_o), int'(e_stb));
        chk("R2", int'(line_ref_o), int'(e_lref));
        rise = lr && !m_prev;
        ph   = rise ? 0 : m_ph;
        if (mode == 2'd0)      req_exp = colour_code(ph);
        else if (mode == 2'd1) req_exp = 0;
        else                   req_exp = 3;
        take_exp = lr && (ph % 2 == 0);
        t = (tg < 0) ? req_exp : tg;
        lref = lr;
        data = d[7:0];
        tag  = t[1:0];
        #1;
        chk(lr ? "R5" : "R3", int'(take_o), int'(take_exp));
        chk((mode == 2'd0) ? "R6" : "R7", int'(req_o), req_exp);
        // Model update for the coming edge.
        if (mode == 2'd0 && take_exp && t == 1) ph = 0;
        if (lr) begin
            if (take_exp) begin
                m_hold = d & 255;
                e_nib  = (d >> 4) & 15;
            end else begin
                e_nib = m_hold & 15;
            end
            m_ph = (mode == 2'd0) ? (ph + 1) % 8 : (ph + 1) % 2;
        end else begin
            e_nib = 0;
            m_ph  = 0;
        end
        e_stb  = lr;
        e_lref = lr;
        m_prev = lr;
    endtask

    task automatic line(input int len, input int seed, input int tagmode);
        for (int k = 0; k < len; k++) begin
            int tg;
            if (tagmode == 0)      tg = -1;
            else if (tagmode == 1) tg = k % 4;
            else                   tg = (k == 4) ? 1 : -1;
            cyc(1'b1, (k * 37 + seed) & 255, tg);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, 8'hA5, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        mode  = 2'd0;
        lref  = 1'b0;
        data  = 8'h00;
        tag   = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", int'(nib_o), 0);
        chk("R1", int'(nib_stb_o), 0);
        chk("R1", int'(line_ref_o), 0);
        chk("R1", int'(take_o), 0);
        rst_n = 1'b1;

        cur_req = "R4"; mode = 2'd0;
        line(16, 5, 0);
        cur_req = "R3";
        idle(3);

        cur_req = "R8";
        line(10, 91, 2);
        idle(2);

        cur_req = "R9"; mode = 2'd1;
        line(10, 200, 1);
        idle(1);
        mode = 2'd2;
        line(6, 17, 1);
        idle(1);

        cur_req = "R10";
        line(7, 60, 1);
        idle(1);
        mode = 2'd0;
        line(6, 130, 0);
        mode = 2'd3;
        line(3, 44, 0);
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule